// File: doc/BRIEF.md
# Byte Popcount Parity Flip Coder

This block is the line-coding stage that sits between a word scrambler and a serializer. On the way out it takes an 18-bit scrambled word, made of 16 payload bits and two marker bits, and widens it to a 20-bit line symbol. The 16-bit payload is handled as two 8-bit halves. Each half is weighed by counting its set bits. A light half is sent inverted and a heavy half is sent as it is, and a keep bit beside the half records which was done. The marker of each half is folded with that half's parity before it goes on the line.

On the way in, the same unit runs in reverse. It re-inverts halves whose keep bit is clear and unfolds the parity to recover the markers. It raises an error when a half arrives lighter than the encoder could ever have sent it. The result is a 25% overhead, zero runs no longer than 9 bits, and detection of any odd number of bit flips that land in the marker and payload bits of one half.

A direction input selects the mode for each transfer. Both directions share the bit counters, the inverters and the parity trees, and both have a latency of one register stage.

Top module: `pcf_coder`

## Requirements
- R1: The data-side word is {marker_hi, marker_lo, payload[15:0]}, and the high half is payload[15:8]. The line symbol, from MSB to LSB, is {keep_hi, linemark_hi, byte_hi[7:0], keep_lo, linemark_lo, byte_lo[7:0]}.
- R2: In encode mode, a half with fewer than 4 set bits is sent inverted with its keep bit 0. A half with 4 or more set bits, including exactly 4, is sent unchanged with its keep bit 1.
- R3: In encode mode, each line marker equals the data marker XOR the even parity (XOR of all bits) of the original payload half.
- R4: No encoded symbol, and no stream of back-to-back encoded symbols sent MSB first, contains more than 9 consecutive zero bits. A payload half 0xF0 followed by a low half 0xE0 with marker_lo 1 reaches exactly 9.
- R5: In decode mode, every symbol produced by the encoder is turned back into the exact original 18-bit word, with err_out low.
- R6: In decode mode, err_out is 1 when any half has keep bit 0 and fewer than 5 set bits in its received byte, or keep bit 1 and fewer than 4 set bits. Otherwise it is 0.
- R7: When any odd number of bits (1, 3, ...) among the 9 linemark and byte bits of one half is flipped in an encoded symbol, decoding raises err_out or returns a marker for that half that differs from the original.
- R8: out_valid is in_valid delayed by exactly one clock, and the result of a transfer appears in the same cycle that out_valid rises.
- R9: While in_valid is low, word_out, sym_out and err_out hold their values. An encode transfer leaves err_out at 0 and does not change word_out. A decode transfer does not change sym_out.
- R10: During and right after an active-low reset, out_valid, err_out, word_out and sym_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_mode | input | 1 | 0 selects encode, 1 selects decode for this transfer |
| in_valid | input | 1 | Input word or symbol is present this cycle |
| word_in | input | 18 | Data-side word to encode |
| sym_in | input | 20 | Line symbol to decode |
| out_valid | output | 1 | Result registered from the previous cycle |
| word_out | output | 18 | Decoded data-side word |
| sym_out | output | 20 | Encoded line symbol |
| err_out | output | 1 | Decoded symbol violates the weight rules |

## Verification
The bench goes after the weight threshold itself. A half with exactly 4 ones must stay unchanged, while 3 ones must flip. On the decode side, a flipped half with 4 ones must be rejected and one with 5 must be accepted. An off-by-one comparison in either direction shows up as a wrong symbol or as a missing or spurious error. A keep bit of the wrong polarity would allow a 10-zero run, so the bench builds the worst-case pair of halves, checks the 9-zero bound on it, and tracks runs across a random stream. Every 1-bit and 3-bit corruption of the marker and byte bits of each half is also decoded. A decoder that took the parity from the wrong byte, or left the marker unfolded, would let some of these corruptions through unflagged.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    // default geometry of the coder
    localparam int HALF_W_DEF = 8;
    localparam int HALVES_DEF = 2;

    // transfer direction carried on dec_mode
    typedef enum logic {
        DIR_ENC = 1'b0,
        DIR_DEC = 1'b1
    } dir_e;

endpackage

// File: rtl/pcf_popcount.sv
module pcf_popcount #(
    parameter int W = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits_i,
    output logic [CNT_W-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CNT_W'(bits_i[i]);
        end
    end

endmodule

// File: rtl/pcf_half_lane.sv
// One half of the coder. The bit counter, the inverter and the parity tree
// serve both directions.
module pcf_half_lane
    import pcf_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  dir_e              dir_i,
    input  logic [HALF_W-1:0] byte_i,
    input  logic              mark_i,
    input  logic              keep_i,
    output logic [HALF_W-1:0] byte_o,
    output logic              mark_o,
    output logic              keep_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(HALF_W + 1);
    // smallest weight sent unchanged, smallest weight of an inverted half
    localparam logic [CNT_W-1:0] KEEP_MIN = CNT_W'(HALF_W / 2);
    localparam logic [CNT_W-1:0] FLIP_MIN = CNT_W'(HALF_W / 2 + 1);

    logic [CNT_W-1:0] weight;
    logic             parity;
    logic             keep_sel;

    pcf_popcount #(.W(HALF_W)) i_popcount (
        .bits_i  (byte_i),
        .count_o (weight)
    );

    // complementing an even-width byte leaves its parity unchanged, so the
    // parity of the incoming byte serves both directions
    assign parity = ^byte_i;

    always_comb begin
        if (dir_i == DIR_ENC) begin
            keep_sel = (weight >= KEEP_MIN);
            err_o    = 1'b0;
        end else begin
            keep_sel = keep_i;
            err_o    = keep_i ? (weight < KEEP_MIN) : (weight < FLIP_MIN);
        end
        keep_o = keep_sel;
        byte_o = keep_sel ? byte_i : ~byte_i;
        mark_o = mark_i ^ parity;
    end

endmodule

// File: rtl/pcf_coder.sv
module pcf_coder
    import pcf_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    parameter int HALVES = HALVES_DEF
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               dec_mode,
    input  logic                               in_valid,
    input  logic [HALVES*(HALF_W+1)-1:0]       word_in,
    input  logic [HALVES*(HALF_W+2)-1:0]       sym_in,
    output logic                               out_valid,
    output logic [HALVES*(HALF_W+1)-1:0]       word_out,
    output logic [HALVES*(HALF_W+2)-1:0]       sym_out,
    output logic                               err_out
);

    localparam int DATA_W = HALVES * HALF_W;
    localparam int WORD_W = DATA_W + HALVES;
    localparam int SEG_W  = HALF_W + 2;
    localparam int SYM_W  = HALVES * SEG_W;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [SYM_W-1:0]  sym;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t state_d, state_q;
    dir_e   dir;

    logic [HALVES-1:0]   lane_err;
    logic [SYM_W-1:0]    sym_asm;
    logic [WORD_W-1:0]   word_asm;

    assign dir = dir_e'(dec_mode);

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_lane
            logic [HALF_W-1:0] byte_in, byte_out;
            logic              mark_in, keep_in, mark_out, keep_out;

            // pick the half from the data-side word or the line symbol
            always_comb begin
                if (dir == DIR_ENC) begin
                    byte_in = word_in[h*HALF_W +: HALF_W];
                    mark_in = word_in[DATA_W + h];
                    keep_in = 1'b1;
                end else begin
                    byte_in = sym_in[h*SEG_W +: HALF_W];
                    mark_in = sym_in[h*SEG_W + HALF_W];
                    keep_in = sym_in[h*SEG_W + HALF_W + 1];
                end
            end

            pcf_half_lane #(.HALF_W(HALF_W)) i_lane (
                .dir_i  (dir),
                .byte_i (byte_in),
                .mark_i (mark_in),
                .keep_i (keep_in),
                .byte_o (byte_out),
                .mark_o (mark_out),
                .keep_o (keep_out),
                .err_o  (lane_err[h])
            );

            assign sym_asm[h*SEG_W +: SEG_W]   = {keep_out, mark_out, byte_out};
            assign word_asm[h*HALF_W +: HALF_W] = byte_out;
            assign word_asm[DATA_W + h]         = mark_out;
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            if (dir == DIR_ENC) begin
                state_d.sym = sym_asm;
                state_d.err = 1'b0;
            end else begin
                state_d.word = word_asm;
                state_d.err  = |lane_err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign err_out   = state_q.err;
    assign sym_out   = state_q.sym;
    assign word_out  = state_q.word;

endmodule

// File: rtl/pcf_coder_chk.sv
module pcf_coder_chk #(
    parameter int HALF_W = 8,
    parameter int HALVES = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dec_mode,
    input logic                         in_valid,
    input logic                         out_valid,
    input logic [HALVES*(HALF_W+1)-1:0] word_out,
    input logic [HALVES*(HALF_W+2)-1:0] sym_out,
    input logic                         err_out
);

    localparam int SEG_W   = HALF_W + 2;
    localparam int SYM_W   = HALVES * SEG_W;
    localparam int MAX_RUN = HALF_W + 1;

    int   run;
    logic long_zero;
    logic weight_ok;

    always_comb begin
        run       = 0;
        long_zero = 1'b0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            if (sym_out[i]) run = 0;
            else            run = run + 1;
            if (run > MAX_RUN) long_zero = 1'b1;
        end
    end

    always_comb begin
        weight_ok = 1'b1;
        for (int h = 0; h < HALVES; h++) begin
            if (sym_out[h*SEG_W + HALF_W + 1]) begin
                if ($countones(sym_out[h*SEG_W +: HALF_W]) < HALF_W / 2) weight_ok = 1'b0;
            end else begin
                if ($countones(sym_out[h*SEG_W +: HALF_W]) < HALF_W / 2 + 1) weight_ok = 1'b0;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sym_out) && $stable(word_out) && $stable(err_out))); // R9
    AST_NO_ERR_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode) |=> !err_out); // R9
    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode) |=> !long_zero); // R4
    AST_KEEP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode) |=> weight_ok); // R2

endmodule

bind pcf_coder pcf_coder_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) i_pcf_coder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_mode  (dec_mode),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .word_out  (word_out),
    .sym_out   (sym_out),
    .err_out   (err_out)
);

// File: tb/test_pcf_coder.sv
module test_pcf_coder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] word_in = '0;
    logic [19:0] sym_in = '0;
    logic        out_valid;
    logic [17:0] word_out;
    logic [19:0] sym_out;
    logic        err_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    pcf_coder i_pcf_coder (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_mode  (dec_mode),
        .in_valid  (in_valid),
        .word_in   (word_in),
        .sym_in    (sym_in),
        .out_valid (out_valid),
        .word_out  (word_out),
        .sym_out   (sym_out),
        .err_out   (err_out)
    );

    // {word[17:0], symbol[19:0]} computed by hand from R1..R3
    localparam logic [37:0] VEC [7] = '{
        {18'h00000, 20'h3FCFF},
        {18'h3FFFF, 20'hFFFFF},
        {18'h00F0F, 20'h83E0F},
        {18'h10107, 20'h7F8F8},
        {18'h21F80, 20'h87D7F},
        {18'h0F000, 20'hBC0FF},
        {18'h1F0E0, 20'hBC01F}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic dec, input logic [17:0] w, input logic [19:0] s);
        @(negedge clk);
        dec_mode = dec;
        word_in  = w;
        sym_in   = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic int max_zero_run(input logic [19:0] s);
        int run = 0;
        int best = 0;
        for (int i = 19; i >= 0; i--) begin
            run = s[i] ? 0 : run + 1;
            if (run > best) best = run;
        end
        return best;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [17:0] w;
        logic [19:0] s;
        int          stream_run;
        int          stream_max;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 0 && err_out == 0, "R10 valid/err in reset", {out_valid, err_out}, 0);
        check(word_out == 0 && sym_out == 0, "R10 data in reset", {word_out, sym_out[13:0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && sym_out == 0 && word_out == 0, "R10 after release", sym_out, 0);

        // R1 R2 R3 R5: table walk, encode then decode each vector
        foreach (VEC[i]) begin
            xfer(1'b0, VEC[i][37:20], 20'h0);
            check(sym_out == VEC[i][19:0], "R1 R2 R3 encode vector", sym_out, VEC[i][19:0]);
            check(err_out == 0, "R9 no err on encode", err_out, 0);
            xfer(1'b1, 18'h0, VEC[i][19:0]);
            check(word_out == VEC[i][37:20], "R5 decode vector", word_out, VEC[i][37:20]);
            check(err_out == 0, "R6 clean symbol", err_out, 0);
        end

        // R4: worst-case pair reaches exactly 9 zeros
        xfer(1'b0, 18'h1F0E0, 20'h0);
        check(max_zero_run(sym_out) == 9, "R4 worst-case run", max_zero_run(sym_out), 9);

        // R8: latency
        @(negedge clk);
        dec_mode = 1'b0; word_in = 18'h00F0F; in_valid = 1'b1;
        check(out_valid == 0, "R8 not before edge", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1 && sym_out == 20'h83E0F, "R8 one cycle", sym_out, 20'h83E0F);
        @(negedge clk);
        check(out_valid == 0, "R8 valid drops", out_valid, 0);

        // R9: hold while idle
        word_in = 18'h3FFFF; sym_in = 20'h00000; dec_mode = 1'b1;
        repeat (2) @(negedge clk);
        check(sym_out == 20'h83E0F, "R9 sym holds idle", sym_out, 20'h83E0F);
        check(word_out == 18'h1F0E0 - 18'h1F0E0 + VEC[6][37:20] && err_out == 0, "R9 word holds idle", word_out, VEC[6][37:20]);

        // R6: weight thresholds on decode
        xfer(1'b1, 18'h0, 20'hFFE07);
        check(err_out == 1, "R6 keep half weight 3", err_out, 1);
        check(sym_out == 20'h83E0F, "R9 decode leaves sym", sym_out, 20'h83E0F);
        xfer(1'b1, 18'h0, 20'hFFCF0);
        check(err_out == 1, "R6 flipped half weight 4", err_out, 1);
        xfer(1'b1, 18'h0, 20'hFFCF8);
        check(err_out == 0, "R6 flipped half weight 5", err_out, 0);
        check(word_out == 18'h3FF07, "R5 flipped weight 5 restore", word_out, 18'h3FF07);
        xfer(1'b1, 18'h0, 20'hFFE0F);
        check(err_out == 0, "R6 keep half weight 4", err_out, 0);
        w = word_out;
        xfer(1'b0, 18'h00000, 20'h0);
        check(err_out == 0, "R9 encode clears err", err_out, 0);
        check(word_out == w, "R9 encode leaves word", word_out, w);

        // R4 R5: random round trips with stream zero-run tracking
        stream_run = 0;
        stream_max = 0;
        for (int n = 0; n < 400; n++) begin
            w = 18'($urandom);
            if (n % 4 == 0) w[15:0] = 16'($urandom) & 16'h8181;
            xfer(1'b0, w, 20'h0);
            s = sym_out;
            for (int b = 19; b >= 0; b--) begin
                stream_run = s[b] ? 0 : stream_run + 1;
                if (stream_run > stream_max) stream_max = stream_run;
            end
            xfer(1'b1, 18'h0, s);
            check(word_out == w && err_out == 0, "R5 random round trip", word_out, w);
        end
        check(stream_max <= 9, "R4 stream zero run", stream_max, 9);

        // R7: every 1-bit and 3-bit corruption inside one half
        for (int k = 0; k < 4; k++) begin
            w = (k == 0) ? 18'h2A5C3 : 18'($urandom);
            xfer(1'b0, w, 20'h0);
            s = sym_out;
            for (int h = 0; h < 2; h++) begin
                for (int m = 1; m < 512; m++) begin
                    if ($countones(m) == 1 || $countones(m) == 3) begin
                        logic [19:0] bad;
                        bad = s ^ (20'(m) << (h * 10));
                        xfer(1'b1, 18'h0, bad);
                        check(err_out == 1 || word_out[16 + h] != w[16 + h],
                              "R7 odd error flagged", {err_out, word_out[16 + h]}, m);
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule